// File: doc/BRIEF.md
# External Interrupt Source Selector

This block decides which GPIO port feeds each of sixteen external interrupt lines. For every line a 4-bit port code is kept in a small register bank that a bus master can write and read. The selector does not combine pins across positions: line n can only ever see pin n of some port, and the port code picks which one. The level of the chosen pin passes straight to the line output, which feeds an interrupt controller further on.

The pin levels come in on one flat vector, grouped by port: bit `p*16 + n` is pin n of port p. There are four selection registers, each holding the codes for four neighbouring lines in its low half. The upper half of each register is reserved. After reset every code is zero, so port A drives all sixteen lines. A code at or above the number of ports that are fitted ties its line low.

Top module: `exti_src_sel`

## Requirements
- R1: After reset every selection register reads 0x00000000, and line n follows pin n of port A (flat input bit n).
- R2: A write to byte offset 0x08, 0x0C, 0x10 or 0x14 stores bits [15:0] of the write data in selection register 0, 1, 2 or 3. A read at the same offset returns the stored value.
- R3: Bits [31:16] of every selection register always read as zero, whatever value was written.
- R4: The code for line n is bits [4*(n%4)+3 : 4*(n%4)] of selection register n/4.
- R5: When line n holds a code p below the number of ports, line n equals flat input bit p*16+n. Code 0 means port A and code 1 means port B. Writing 0x0010 to register 0 routes input 17 to line 1, and writing 0x0001 routes input 16 to line 0.
- R6: A pin from a port that is not selected for its line has no effect on that line.
- R7: Raising pin n of the selected port drives only line n. Every other line stays low.
- R8: A code equal to or above the number of ports (8 by default) holds its line at 0.
- R9: The lines are combinational in the pins and the codes. A new code takes effect right after the clock edge that stores it, and a pin change shows on the line in the same cycle.
- R10: Writes to any other offset, or to an offset that is not 4-byte aligned, change no register. Reads at such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pins_i | input | 128 | GPIO pin levels, bit p*16+n is port p pin n |
| lines_o | output | 16 | Interrupt line levels |

## Verification
The hardest behaviour to reach is a pin that is not selected. A port whose pins are not routed to a line never appears on the outputs, so a fault that lets such a pin leak through stays hidden unless the stimulus raises exactly that pin after its line has been pointed at a different port. The vector table therefore writes a code, raises one pin at a time (sometimes the selected pin, sometimes its neighbour on a port that is not selected) and compares all sixteen lines together. This is followed by directed cases for the unfitted code values, the reserved upper bits, decoding of stray addresses, and the cycle in which a new code takes effect.

// File: rtl/exti_src_sel_pkg.sv
package exti_src_sel_pkg;
  localparam int unsigned NUM_LINES_D     = 16;
  localparam int unsigned NUM_PORTS_D     = 8;
  localparam int unsigned SEL_W_D         = 4;
  localparam int unsigned LINES_PER_REG_D = 4;
  localparam int unsigned ADDR_W_D        = 8;
  localparam int unsigned DATA_W_D        = 32;
  localparam int unsigned BASE_OFF_D      = 8;
endpackage

// File: rtl/exti_sel_regs.sv
module exti_sel_regs #(
  parameter int unsigned NUM_LINES     = 16,
  parameter int unsigned SEL_W         = 4,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned BASE_OFF      = 8,
  localparam int unsigned NUM_REGS     = NUM_LINES / LINES_PER_REG,
  localparam int unsigned FIELD_BITS   = LINES_PER_REG * SEL_W,
  localparam int unsigned IDX_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_LINES*SEL_W-1:0] sel_o
);
  logic [FIELD_BITS-1:0] regs_q [NUM_REGS];
  logic [ADDR_W-1:0]     off;
  logic                  hit;
  logic [IDX_W-1:0]      idx;
  logic [NUM_REGS-1:0]   wr_en;

  always_comb begin
    off = addr_i - ADDR_W'(BASE_OFF);
    hit = (addr_i >= ADDR_W'(BASE_OFF)) && (addr_i[1:0] == 2'b00) &&
          ((off >> 2) < ADDR_W'(NUM_REGS));
    idx = IDX_W'(off >> 2);
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    assign wr_en[k] = we_i && hit && (idx == IDX_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       regs_q[k] <= '0;
      else if (wr_en[k]) regs_q[k] <= wdata_i[FIELD_BITS-1:0];
    end

    assign sel_o[k*FIELD_BITS +: FIELD_BITS] = regs_q[k];

    p_write_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en[k] |=> regs_q[k] == $past(wdata_i[FIELD_BITS-1:0]));
    p_hold_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en[k] |=> $stable(regs_q[k]));
  end

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o = {{(DATA_W-FIELD_BITS){1'b0}}, regs_q[idx]};
  end

  p_onehot_wr_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));
  p_hi_zero_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:FIELD_BITS] == '0);
endmodule

// File: rtl/exti_line_mux.sv
module exti_line_mux #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned SEL_W     = 4
) (
  input  logic [NUM_PORTS-1:0] col_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 line_o
);
  // codes with no fitted port match nothing and leave the line low
  always_comb begin
    line_o = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (sel_i == SEL_W'(p)) line_o = col_i[p];
  end
endmodule

// File: rtl/exti_src_sel.sv
module exti_src_sel
  import exti_src_sel_pkg::*;
#(
  parameter int unsigned NUM_LINES     = NUM_LINES_D,
  parameter int unsigned NUM_PORTS     = NUM_PORTS_D,
  parameter int unsigned SEL_W         = SEL_W_D,
  parameter int unsigned LINES_PER_REG = LINES_PER_REG_D,
  parameter int unsigned ADDR_W        = ADDR_W_D,
  parameter int unsigned DATA_W        = DATA_W_D,
  parameter int unsigned BASE_OFF      = BASE_OFF_D,
  localparam int unsigned PIN_W        = NUM_PORTS * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [PIN_W-1:0]     pins_i,
  output logic [NUM_LINES-1:0] lines_o
);
  logic [NUM_LINES*SEL_W-1:0] sel;

  exti_sel_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .LINES_PER_REG(LINES_PER_REG),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_OFF(BASE_OFF)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sel_o(sel)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] col;
    logic [SEL_W-1:0]     code;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
      assign col[p] = pins_i[p*NUM_LINES + n];
    end
    assign code = sel[n*SEL_W +: SEL_W];

    exti_line_mux #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_mux (
      .col_i(col), .sel_i(code), .line_o(lines_o[n])
    );

    p_route_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(code) < NUM_PORTS) |-> lines_o[n] == pins_i[int'(code)*NUM_LINES + n]);
    p_unfitted_low_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(code) >= NUM_PORTS) |-> !lines_o[n]);
  end
endmodule

// File: tb/exti_src_sel_tb_top.sv
module exti_src_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int NP = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         we = 0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] pins = '0;
  logic [15:0]  lines;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exti_src_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pins_i(pins), .lines_o(lines)
  );

  // {reg[1:0], wdata[15:0], pin[6:0], expected lines[15:0]}
  localparam int NV = 12;
  localparam logic [40:0] VEC [NV] = '{
    {2'd0, 16'h0000, 7'd0,   16'h0001},  // R1 default port A
    {2'd0, 16'h0000, 7'd15,  16'h8000},  // R1
    {2'd0, 16'h0010, 7'd17,  16'h0002},  // R5 B1 -> line1
    {2'd0, 16'h0010, 7'd16,  16'h0000},  // R6 B0 unselected
    {2'd0, 16'h0001, 7'd16,  16'h0001},  // R5 B0 -> line0
    {2'd0, 16'h0001, 7'd0,   16'h0000},  // R6 A0 unselected
    {2'd0, 16'h0000, 7'd2,   16'h0004},  // R7 pin2 only line2
    {2'd3, 16'hF000, 7'd15,  16'h0000},  // R8 code 15
    {2'd3, 16'h7000, 7'd127, 16'h8000},  // R4 line15 port7
    {2'd2, 16'h0300, 7'd58,  16'h0400},  // R4 line10 port3
    {2'd1, 16'h0050, 7'd85,  16'h0020},  // R4 line5 port5
    {2'd1, 16'h0050, 7'd5,   16'h0000}   // R6 A5 unselected
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    logic [31:0] r;
    do_reset();

    // R1 reset values
    for (int k = 0; k < 4; k++) begin
      rd(8'(8 + 4*k), r);
      check("R1", r, 32'h0);
    end
    @(negedge clk); pins = {112'h0, 16'hFFFF}; #1;
    check("R1", {16'h0, lines}, 32'h0000FFFF);
    pins = {16'h0, 112'h0} | {16'hFFFF, 112'h0}; #1;
    check("R6", {16'h0, lines}, 32'h0);
    pins = '0;

    // R7 one-hot sweep on port A
    for (int n = 0; n < NL; n++) begin
      @(negedge clk); pins = '0; pins[n] = 1'b1; #1;
      check("R7", {16'h0, lines}, 32'(1) << n);
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(8'(8 + 4*int'(VEC[v][40:39])), {16'h0, VEC[v][38:23]});
      @(negedge clk); pins = '0; pins[VEC[v][22:16]] = 1'b1; #1;
      check("R5", {16'h0, lines}, {16'h0, VEC[v][15:0]});
    end

    // R2/R3 readback and reserved bits
    wr(8'h0C, 32'hFFFF_A5C3);
    rd(8'h0C, r); check("R3", r, 32'h0000A5C3);
    rd(8'h14, r); check("R2", r, 32'h00007000);
    rd(8'h10, r); check("R2", r, 32'h00000300);

    // R10 stray offsets
    wr(8'h04, 32'h0000_1111);
    wr(8'h18, 32'h0000_2222);
    wr(8'h09, 32'h0000_3333);
    rd(8'h08, r); check("R10", r, 32'h00000000);
    rd(8'h0C, r); check("R10", r, 32'h0000A5C3);
    rd(8'h04, r); check("R10", r, 32'h0);
    rd(8'h18, r); check("R10", r, 32'h0);

    // R8 every line on code 8 with all pins high
    for (int k = 0; k < 4; k++) wr(8'(8 + 4*k), 32'h0000_8888);
    @(negedge clk); pins = '1; #1;
    check("R8", {16'h0, lines}, 32'h0);

    // R9 new code takes effect right after its write edge
    for (int k = 0; k < 4; k++) wr(8'(8 + 4*k), 32'h0);
    @(negedge clk); pins = '0; pins[2*NL + 3] = 1'b1; #1;
    check("R9", {16'h0, lines}, 32'h0);
    we = 1; addr = 8'h08; wdata = 32'h0000_2000;
    @(posedge clk); #1; we = 0;
    check("R9", {16'h0, lines}, 32'h0008);
    pins[2*NL + 3] = 1'b0; #1;
    check("R9", {16'h0, lines}, 32'h0);

    // R1 reset clears codes
    do_reset();
    rd(8'h08, r); check("R1", r, 32'h0);
    @(negedge clk); pins = '0; pins[3] = 1'b1; #1;
    check("R1", {16'h0, lines}, 32'h0008);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule